// File: doc/BRIEF.md
# Microcontroller General-Purpose Port Group Controller

This block manages a set of 4-bit general-purpose ports beside a small microcontroller core. The group holds dedicated input ports, dedicated output ports and two bidirectional ports. The direction of one bidirectional port (the "implicit" port) is never written directly. It follows the class of the last operation the core aimed at it. A read or a bit test turns all four of its pins into inputs, and a write, bit set or bit clear turns all four into outputs. The other bidirectional port (the "per-pin" port) takes a separate direction bit for each pin from a dedicated direction-set command.

The core presents one decoded operation per cycle, together with a port address, write data and a bit index. The block drives the pad output values, the output enables, the input enables and the grouped pull-down enables. A synchronous active-low reset returns the group to a safe state. A backup input puts the group into a low-power state: nothing is driven and no input is sampled.

Top module: `port_group_ctrl`

## Requirements
- R1: After a clock edge with `rst_n` low, every dedicated output port drives 0 with its output enable high, both bidirectional ports are inputs (output enable 0), all output latches hold 0, and `rd_data_o` and `test_o` are 0.
- R2: An operation of the read class aimed at the implicit port (address 4) sets all four of its output enables to 0 from the next cycle. The read class is op 1 read, op 2 test-true and op 3 test-false.
- R3: An operation of the output class aimed at the implicit port sets all four of its output enables to 1 from the next cycle, and the pins drive the latch. The output class is op 4 write, op 5 set-bit and op 6 clear-bit.
- R4: Op 7 (direction set) aimed at the per-pin port (address 5) loads `data_i` as its direction, where bit i set to 1 makes pin i an output. Writes to that port do not change its direction, and op 7 aimed at any other port has no effect.
- R5: Set-bit and clear-bit change only bit `bit_i` of the addressed port's output latch and leave the other three bits unchanged.
- R6: A port's output latch keeps its value while the port is an input, and the pins drive that value again as soon as they return to output mode.
- R7: While `backup_i` is 1, all output enables and input enables are 0. Write, set-bit, clear-bit and direction-set operations have no effect, and both bidirectional ports are forced to input.
- R8: A read-class operation issued while `backup_i` is 1 returns 0 for the input and bidirectional ports.
- R9: After `backup_i` falls, both bidirectional ports are inputs and every output latch holds the value it had before backup.
- R10: The pull-down enables of dedicated input port k are all four equal to bit k of parameter `PD_OPT`.
- R11: A read-class operation registers its result one cycle later. `rd_data_o` takes the port view: the pad value for input and bidirectional ports, the latch for dedicated output ports, and 0 for unused addresses. `test_o` takes bit `bit_i` of that view for op 2, its inverse for op 3, and the bit itself for op 1.
- R12: Port addresses are fixed: 0..NIN-1 are dedicated inputs, then NOUT dedicated outputs, then the implicit port, then the per-pin port. Writes to a dedicated input port change nothing at the pads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| backup_i | input | 1 | Low-power backup state request |
| op_i | input | 3 | Decoded operation code (0 none, 1..7 as in the requirements) |
| addr_i | input | AW (3) | Target port address |
| data_i | input | W (4) | Write or direction data |
| bit_i | input | BW (2) | Bit index for set, clear and test |
| pad_i | input | NPORT*W (24) | Pad input values, port p at bits p*W+:W |
| pad_o | output | NPORT*W (24) | Pad output values |
| pad_oe_o | output | NPORT*W (24) | Pad output enables |
| pad_ie_o | output | NPORT*W (24) | Pad input enables |
| pad_pd_o | output | NIN*W (8) | Pull-down enables of the dedicated input ports |
| rd_data_o | output | W (4) | Registered read result |
| test_o | output | 1 | Registered bit-test result |

## Verification
The hardest situation to reach is the interaction between backup and the two bidirectional ports. Both must leave backup as inputs even though, before backup, one was in output mode through an implicit write and the other through a direction command. Their latches must also survive so that the next output operation drives the old values. Directed sequences first put both ports into output mode and then enter backup. Inside backup they issue ignored writes and gated reads, and after leaving backup they check the directions and latch contents. Random stimulus at a fixed seed also toggles backup and reset between random operations, so that these transitions occur at many latch and direction states.

// File: rtl/mpc_pkg.sv
// Shared definitions for the port group controller.
// Assumes the core issues at most one decoded operation per cycle.
package mpc_pkg;
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_READ   = 3'd1,
        OP_TSTT   = 3'd2,
        OP_TSTF   = 3'd3,
        OP_WRITE  = 3'd4,
        OP_SETB   = 3'd5,
        OP_CLRB   = 3'd6,
        OP_DIRSET = 3'd7
    } port_op_e;
endpackage

// File: rtl/mpc_wr_latch.sv
// Output latch of one writable port: a whole-word write or a single-bit
// set/clear. Assumes at most one of wr_en, set_en, clr_en is high.
module mpc_wr_latch #(
    parameter int W  = 4,
    parameter int BW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          set_en,
    input  logic          clr_en,
    input  logic [BW-1:0] bit_sel,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  q
);
    localparam logic [W-1:0] ONE = W'(1);

    // Latch update: reset to zero, word write, or single-bit modify.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (wr_en)  q <= wdata;
        else if (set_en) q[bit_sel] <= 1'b1;
        else if (clr_en) q[bit_sel] <= 1'b0;
    end

    // R5
    set_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> (q == ($past(q) | (ONE << $past(bit_sel)))));
    // R5
    clr_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> (q == ($past(q) & ~(ONE << $past(bit_sel)))));
    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !set_en && !clr_en) |=> $stable(q));
endmodule

// File: rtl/mpc_imp_dir.sv
// Direction flag of the implicitly directed port: the last read-class
// operation makes it input, the last output-class operation makes it output.
// Assumes in_op and out_op are never high together.
module mpc_imp_dir (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_in,
    input  logic in_op,
    input  logic out_op,
    output logic out_mode
);
    // Direction flag: reset and backup force input.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_in) out_mode <= 1'b0;
        else if (in_op)        out_mode <= 1'b0;
        else if (out_op)       out_mode <= 1'b1;
    end

    // R2
    imp_to_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_op |=> !out_mode);
    // R3
    imp_to_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_op && !hold_in) |=> out_mode);
    // R9
    imp_exit_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_in) |-> !out_mode);
endmodule

// File: rtl/mpc_pin_dir.sv
// Per-pin direction register of the explicitly directed port, loaded by the
// direction-set command. Assumes set_en is already gated by backup.
module mpc_pin_dir #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold_in,
    input  logic         set_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir
);
    // Direction register: reset and backup clear every pin to input.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_in) dir <= '0;
        else if (set_en)       dir <= wdata;
    end

    // R4
    dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !hold_in) |=> (dir == $past(wdata)));
    // R9
    dir_exit_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_in) |-> (dir == '0));
endmodule

// File: rtl/port_group_ctrl.sv
// Port group controller: decodes one core operation per cycle onto
// dedicated input, dedicated output, implicitly directed and per-pin
// directed 4-bit ports, and drives pad values and enables.
// Assumes op_i is a one-cycle decoded strobe. Reset is synchronous active-low.
module port_group_ctrl #(
    parameter int NIN    = 2,
    parameter int NOUT   = 2,
    parameter int W      = 4,
    parameter int PD_OPT = 2,
    parameter int NPORT  = NIN + NOUT + 2,
    parameter int AW     = $clog2(NPORT),
    parameter int BW     = $clog2(W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 backup_i,
    input  logic [2:0]           op_i,
    input  logic [AW-1:0]        addr_i,
    input  logic [W-1:0]         data_i,
    input  logic [BW-1:0]        bit_i,
    input  logic [NPORT*W-1:0]   pad_i,
    output logic [NPORT*W-1:0]   pad_o,
    output logic [NPORT*W-1:0]   pad_oe_o,
    output logic [NPORT*W-1:0]   pad_ie_o,
    output logic [NIN*W-1:0]     pad_pd_o,
    output logic [W-1:0]         rd_data_o,
    output logic                 test_o
);
    import mpc_pkg::*;

    localparam int IMP = NIN + NOUT;
    localparam int PIN = NIN + NOUT + 1;
    localparam logic [NIN-1:0] PD_MASK = PD_OPT[NIN-1:0];

    port_op_e         op;
    logic             is_rd, is_wr, is_set, is_clr, is_dir, act;
    logic [NPORT-1:0] sel;
    logic [W-1:0]     lat  [NPORT];
    logic [W-1:0]     view [NPORT];
    logic [W-1:0]     rd_val;
    logic             imp_out;
    logic [W-1:0]     pin_dir;

    assign op     = port_op_e'(op_i);
    assign is_rd  = (op == OP_READ) || (op == OP_TSTT) || (op == OP_TSTF);
    assign is_wr  = (op == OP_WRITE);
    assign is_set = (op == OP_SETB);
    assign is_clr = (op == OP_CLRB);
    assign is_dir = (op == OP_DIRSET);
    assign act    = !backup_i;

    genvar p;
    generate
        for (p = 0; p < NPORT; p++) begin : g_port
            assign sel[p] = (addr_i == AW'(p));
            if (p < NIN) begin : g_in
                assign lat[p]                = '0;
                assign view[p]               = pad_i[p*W +: W] & {W{act}};
                assign pad_o[p*W +: W]       = '0;
                assign pad_oe_o[p*W +: W]    = '0;
                assign pad_ie_o[p*W +: W]    = {W{act}};
                assign pad_pd_o[p*W +: W]    = {W{PD_MASK[p]}};
            end else begin : g_wr
                mpc_wr_latch #(.W(W), .BW(BW)) u_lat (
                    .clk     (clk),
                    .rst_n   (rst_n),
                    .wr_en   (act && is_wr  && sel[p]),
                    .set_en  (act && is_set && sel[p]),
                    .clr_en  (act && is_clr && sel[p]),
                    .bit_sel (bit_i),
                    .wdata   (data_i),
                    .q       (lat[p])
                );
                assign pad_o[p*W +: W] = lat[p];
                if (p < IMP) begin : g_out
                    assign view[p]            = lat[p];
                    assign pad_oe_o[p*W +: W] = {W{act}};
                    assign pad_ie_o[p*W +: W] = '0;
                end else if (p == IMP) begin : g_imp
                    assign view[p]            = pad_i[p*W +: W] & {W{act}};
                    assign pad_oe_o[p*W +: W] = {W{imp_out && act}};
                    assign pad_ie_o[p*W +: W] = {W{act}};
                end else begin : g_pin
                    assign view[p]            = pad_i[p*W +: W] & {W{act}};
                    assign pad_oe_o[p*W +: W] = pin_dir & {W{act}};
                    assign pad_ie_o[p*W +: W] = {W{act}};
                end
            end
        end
    endgenerate

    mpc_imp_dir u_imp_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_in  (backup_i),
        .in_op    (is_rd && sel[IMP]),
        .out_op   (act && (is_wr || is_set || is_clr) && sel[IMP]),
        .out_mode (imp_out)
    );

    mpc_pin_dir #(.W(W)) u_pin_dir (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_in (backup_i),
        .set_en  (act && is_dir && sel[PIN]),
        .wdata   (data_i),
        .dir     (pin_dir)
    );

    // Read mux: view of the addressed port, zero for unused addresses.
    always_comb begin
        rd_val = '0;
        for (int k = 0; k < NPORT; k++)
            if (sel[k]) rd_val = view[k];
    end

    // Result register: captures read view and bit-test outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o <= '0;
            test_o    <= 1'b0;
        end else if (is_rd) begin
            rd_data_o <= rd_val;
            test_o    <= (op == OP_TSTF) ? !rd_val[bit_i] : rd_val[bit_i];
        end
    end

    // R7
    backup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        backup_i |-> ((pad_oe_o == '0) && (pad_ie_o == '0)));
    // R8
    backup_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (backup_i && is_rd && (addr_i != AW'(NIN)) && (int'(addr_i) >= NIN + NOUT || int'(addr_i) < NIN))
        |=> (rd_data_o == '0));
    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rd |=> ($stable(rd_data_o) && $stable(test_o)));
endmodule

// File: tb/port_group_ctrl_bench.sv
module port_group_ctrl_bench;
    import mpc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        backup_i = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [2:0]  addr_i = 3'd0;
    logic [3:0]  data_i = 4'd0;
    logic [1:0]  bit_i = 2'd0;
    logic [23:0] pad_i = 24'd0;
    logic [23:0] pad_o, pad_oe_o, pad_ie_o;
    logic [7:0]  pad_pd_o;
    logic [3:0]  rd_data_o;
    logic        test_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [3:0] m_lat [6];
    logic       m_imp;
    logic [3:0] m_pdir;
    logic [3:0] m_rd;
    logic       m_tst;

    port_group_ctrl u_port_group_ctrl (
        .clk(clk), .rst_n(rst_n), .backup_i(backup_i), .op_i(op_i),
        .addr_i(addr_i), .data_i(data_i), .bit_i(bit_i), .pad_i(pad_i),
        .pad_o(pad_o), .pad_oe_o(pad_oe_o), .pad_ie_o(pad_ie_o),
        .pad_pd_o(pad_pd_o), .rd_data_o(rd_data_o), .test_o(test_o)
    );

    always #2 clk = ~clk;

    function automatic logic [3:0] view(input int a);
        if (a < 2 || a == 4 || a == 5) return backup_i ? 4'h0 : pad_i[a*4 +: 4];
        if (a == 2 || a == 3) return m_lat[a];
        return 4'h0;
    endfunction

    function automatic logic [23:0] exp_oe();
        logic [23:0] v = '0;
        if (!backup_i) begin
            v[8 +: 8]  = 8'hFF;
            v[16 +: 4] = m_imp ? 4'hF : 4'h0;
            v[20 +: 4] = m_pdir;
        end
        return v;
    endfunction

    function automatic logic [23:0] exp_ie();
        return backup_i ? 24'h0 : 24'hFF_00FF;
    endfunction

    function automatic logic [23:0] exp_po();
        return {m_lat[5], m_lat[4], m_lat[3], m_lat[2], 8'h00};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "pad_o", 32'(pad_o), 32'(exp_po()));
        chk(tag, "pad_oe_o", 32'(pad_oe_o), 32'(exp_oe()));
        chk(tag, "pad_ie_o", 32'(pad_ie_o), 32'(exp_ie()));
        chk(tag, "rd_data_o", 32'(rd_data_o), 32'(m_rd));
        chk(tag, "test_o", 32'(test_o), 32'(m_tst));
    endtask

    // Drive one operation at the falling edge, update the model at the
    // rising edge, and return at the next falling edge for sampling.
    task automatic step(input logic [2:0] op, input int a,
                        input logic [3:0] d, input logic [1:0] b);
        logic [3:0] v;
        op_i = op; addr_i = 3'(a); data_i = d; bit_i = b;
        @(posedge clk);
        if (!rst_n) begin
            for (int k = 0; k < 6; k++) m_lat[k] = 4'h0;
            m_imp = 0; m_pdir = 4'h0; m_rd = 4'h0; m_tst = 0;
        end else begin
            v = view(a);
            if (op >= 3'd1 && op <= 3'd3) begin
                m_rd = v;
                m_tst = (op == 3'd3) ? !v[b] : v[b];
            end
            if (backup_i) begin
                m_imp = 0; m_pdir = 4'h0;
            end else begin
                if (a >= 2 && a <= 5) begin
                    if (op == 3'd4) m_lat[a] = d;
                    if (op == 3'd5) m_lat[a][b] = 1'b1;
                    if (op == 3'd6) m_lat[a][b] = 1'b0;
                end
                if (a == 4 && op >= 3'd4 && op <= 3'd6) m_imp = 1;
                if (a == 4 && op >= 3'd1 && op <= 3'd3) m_imp = 0;
                if (a == 5 && op == 3'd7) m_pdir = d;
            end
        end
        @(negedge clk);
        op_i = 3'd0;
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int k = 0; k < 6; k++) m_lat[k] = 4'h0;
        m_imp = 0; m_pdir = 4'h0; m_rd = 4'h0; m_tst = 0;
        @(negedge clk);
        pad_i = 24'h5A_3C_96;
        // R1: state after reset
        step(OP_NONE, 0, 4'h0, 2'd0);
        step(OP_NONE, 0, 4'h0, 2'd0);
        check_all("R1");
        chk("R1", "out ports drive low enabled", 32'(pad_oe_o[15:8]), 32'hFF);
        rst_n = 1'b1;

        // R10: grouped pull-downs follow the option mask (default 2 -> port 1 only)
        chk("R10", "pad_pd_o", 32'(pad_pd_o), 32'hF0);

        // R3: output-class op makes implicit port an output
        step(OP_WRITE, 4, 4'h9, 2'd0);
        check_all("R3");
        chk("R3", "implicit oe", 32'(pad_oe_o[19:16]), 32'hF);
        // R2: read-class op makes implicit port an input
        step(OP_READ, 4, 4'h0, 2'd0);
        check_all("R2");
        chk("R2", "implicit oe", 32'(pad_oe_o[19:16]), 32'h0);
        chk("R6", "latch kept while input", 32'(pad_o[19:16]), 32'h9);
        // R5/R6: set-bit returns to output with modified latch
        step(OP_SETB, 4, 4'h0, 2'd1);
        check_all("R6");
        chk("R5", "set bit 1", 32'(pad_o[19:16]), 32'hB);
        step(OP_CLRB, 4, 4'h0, 2'd3);
        chk("R5", "clear bit 3", 32'(pad_o[19:16]), 32'h3);
        step(OP_TSTF, 4, 4'h0, 2'd0);
        chk("R2", "test-false switches to input", 32'(pad_oe_o[19:16]), 32'h0);

        // R12: writing a dedicated input port changes nothing
        step(OP_WRITE, 0, 4'hF, 2'd0);
        check_all("R12");
        step(OP_WRITE, 2, 4'hC, 2'd0);
        chk("R12", "output port 2 latch", 32'(pad_o[11:8]), 32'hC);

        // R4: per-pin direction
        step(OP_DIRSET, 5, 4'h5, 2'd0);
        check_all("R4");
        step(OP_WRITE, 5, 4'hA, 2'd0);
        chk("R4", "write keeps per-pin dir", 32'(pad_oe_o[23:20]), 32'h5);
        step(OP_DIRSET, 3, 4'hF, 2'd0);
        check_all("R4");
        chk("R4", "dirset elsewhere ignored", 32'(pad_o[15:12]), 32'h0);

        // R11: read and bit tests
        step(OP_TSTT, 0, 4'h0, 2'd2);
        check_all("R11");
        step(OP_TSTF, 0, 4'h0, 2'd2);
        check_all("R11");
        step(OP_READ, 2, 4'h0, 2'd0);
        chk("R11", "read output port latch", 32'(rd_data_o), 32'hC);
        step(OP_READ, 7, 4'h0, 2'd0);
        chk("R11", "unused address reads 0", 32'(rd_data_o), 32'h0);

        // R7/R8: backup with both bidirectional ports in output mode
        step(OP_WRITE, 4, 4'h6, 2'd0);
        pad_i = 24'hFF_FFFF;
        backup_i = 1'b1;
        #1;
        chk("R7", "all oe off", 32'(pad_oe_o), 32'h0);
        chk("R7", "all ie off", 32'(pad_ie_o), 32'h0);
        step(OP_READ, 1, 4'h0, 2'd0);
        check_all("R8");
        chk("R8", "read in backup", 32'(rd_data_o), 32'h0);
        step(OP_TSTF, 5, 4'h0, 2'd0);
        chk("R8", "test-false in backup", 32'(test_o), 32'h1);
        step(OP_WRITE, 2, 4'h1, 2'd0);
        step(OP_DIRSET, 5, 4'hF, 2'd0);
        step(OP_WRITE, 4, 4'hF, 2'd0);
        check_all("R7");
        // R9: leave backup
        backup_i = 1'b0;
        #1;
        check_all("R9");
        chk("R9", "implicit stays input", 32'(pad_oe_o[19:16]), 32'h0);
        chk("R9", "per-pin stays input", 32'(pad_oe_o[23:20]), 32'h0);
        chk("R9", "latches kept", 32'(pad_o[23:8]), 32'hA6_0C);

        // Random mix with occasional backup and reset
        for (int i = 0; i < 600; i++) begin
            pad_i    = 24'($urandom);
            backup_i = ($urandom_range(0, 7) == 0);
            rst_n    = ($urandom_range(0, 59) != 0);
            step(3'($urandom_range(0, 7)), $urandom_range(0, 7),
                 4'($urandom), 2'($urandom));
            #1;
            check_all("random");
        end

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule